// File: doc/BRIEF.md
# Threshold Trim Programming Sequencer

This block listens to a two-wire serial bus together with a digital qualifier that reports whether a programming voltage is present on a shared output pin. It recognises one special write: a fixed device byte, then a byte that picks one of two voltage trip thresholds, then a zero data byte. When that write is closed by a STOP, the block fires a one-cycle program strobe for the chosen threshold. The analog trim cell and the high-voltage pump are not modelled here.

A trim command is accepted only if the qualifier is already high when the START condition is seen. The block acknowledges each of the three expected bytes by pulling SDA low. After the STOP it raises a busy flag for a fixed self-timed programming period. The operation is complete, and a one-cycle done pulse is given, only once that period has run out and the qualifier has been released. Any other bus traffic gets no response from this block.

Top module: `trim_seq`

## Requirements
- R1: While reset is high and right after it, `sda_pull_o`, `prog1_o`, `prog2_o`, `busy_o` and `done_o` are all 0.
- R2: With `vp_i` high at START, the byte sequence A0h, 01h, 00h and then a STOP gives exactly one `prog1_o` pulse, no `prog2_o` pulse, and `busy_o` goes high.
- R3: The same sequence with 09h as the second byte gives exactly one `prog2_o` pulse and no `prog1_o` pulse.
- R4: For each accepted byte, `sda_pull_o` is low up to the SCL falling edge that ends the eighth bit. It is high during the ninth (acknowledge) clock and is low again after the SCL falling edge that ends that clock.
- R5: If `vp_i` is low at START, none of the bytes is acknowledged and no strobe is produced.
- R6: A first byte other than A0h, a second byte other than 01h or 09h, or a third byte other than 00h is not acknowledged. The command is dropped with no strobe.
- R7: A STOP that arrives before all three bytes have been acknowledged produces no strobe, and `busy_o` stays low.
- R8: Any further SCL clock after the third acknowledge and before the STOP drops the command, and the STOP that follows produces no strobe.
- R9: `busy_o` stays high for as long as `vp_i` stays high. Once `vp_i` is low and the programming period has run out, `busy_o` falls and `done_o` pulses for exactly one cycle.
- R10: If `vp_i` is released early, `busy_o` still stays high for at least `PROG_CYCLES` cycles, and a single `done_o` pulse follows.
- R11: While `busy_o` is high, bus traffic is ignored: no acknowledge and no new strobe.
- R12: If `vp_i` falls in the middle of a command, the command is dropped: the next byte is not acknowledged and no strobe follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised serial clock sample |
| sda_i | input | 1 | Synchronised serial data sample (the wired bus level) |
| vp_i | input | 1 | Programming-voltage-present qualifier |
| sda_pull_o | output | 1 | 1 pulls SDA low (acknowledge) |
| prog1_o | output | 1 | One-cycle program strobe for threshold 1 |
| prog2_o | output | 1 | One-cycle program strobe for threshold 2 |
| busy_o | output | 1 | Programming operation in progress |
| done_o | output | 1 | One-cycle pulse when the operation completes |

## Verification
The assertions assume that SCL and SDA are already synchronised to `clk` and that each SCL level lasts at least one clock. They also assume that SDA changes while SCL is high only to form START or STOP, so that bit edges and bus conditions are never seen in the same cycle. The bench master holds every bus phase for four clocks. It changes data only while SCL is low and releases SDA during each acknowledge clock, so the wired bus level is the AND of the master's drive and the inverse of `sda_pull_o`. The qualifier is changed only between bytes or while the bus is idle.

// File: rtl/trim_pkg.sv
package trim_pkg;

    localparam int BYTE_BITS = 8;
    localparam int CMD_BYTES = 3;

    localparam logic [7:0] DEV_WR  = 8'hA0;
    localparam logic [7:0] ADDR_T1 = 8'h01;
    localparam logic [7:0] ADDR_T2 = 8'h09;
    localparam logic [7:0] DATA_OK = 8'h00;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_ev_t;

    typedef enum logic [2:0] {
        C_IDLE,
        C_RX,
        C_ACKQ,
        C_ACK,
        C_WSTOP
    } cmd_st_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_T1   = 2'd1,
        SEL_T2   = 2'd2
    } trim_sel_t;

    function automatic logic byte_ok(input int unsigned idx, input logic [7:0] b);
        case (idx)
            0:       return b == DEV_WR;
            1:       return (b == ADDR_T1) || (b == ADDR_T2);
            2:       return b == DATA_OK;
            default: return 1'b0;
        endcase
    endfunction

    function automatic trim_sel_t sel_of(input logic [7:0] b);
        if (b == ADDR_T1) return SEL_T1;
        if (b == ADDR_T2) return SEL_T2;
        return SEL_NONE;
    endfunction

endpackage

// File: rtl/trim_bus_mon.sv
module trim_bus_mon
    import trim_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        ev.scl_rise = scl_i & ~scl_q;
        ev.scl_fall = ~scl_i & scl_q;
        ev.start    = scl_i & scl_q & sda_q & ~sda_i;
        ev.stop     = scl_i & scl_q & ~sda_q & sda_i;
        ev.sda      = sda_i;
    end

endmodule

// File: rtl/trim_cmd_fsm.sv
module trim_cmd_fsm
    import trim_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  bus_ev_t   ev,
    input  logic      vp_i,
    input  logic      prog_busy,
    output logic      sda_pull_o,
    output logic      cmd_go,
    output trim_sel_t cmd_sel
);

    localparam int BW = $clog2(BYTE_BITS);
    localparam int IW = $clog2(CMD_BYTES);
    localparam logic [BW-1:0] BIT_LAST  = BW'(BYTE_BITS - 1);
    localparam logic [IW-1:0] BYTE_LAST = IW'(CMD_BYTES - 1);

    cmd_st_t         state;
    logic [BW-1:0]   bitcnt;
    logic [IW-1:0]   idx;
    logic [7:0]      shreg;
    logic [7:0]      nb;

    assign nb = {shreg[6:0], ev.sda};

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= C_IDLE;
            bitcnt  <= '0;
            idx     <= '0;
            shreg   <= '0;
            cmd_sel <= SEL_NONE;
        end else if (prog_busy) begin
            state <= C_IDLE;
        end else if (state != C_IDLE && !vp_i) begin
            state <= C_IDLE;
        end else if (ev.start) begin
            bitcnt <= '0;
            idx    <= '0;
            state  <= vp_i ? C_RX : C_IDLE;
        end else if (ev.stop) begin
            state <= C_IDLE;
        end else begin
            case (state)
                C_RX: if (ev.scl_rise) begin
                    shreg  <= nb;
                    bitcnt <= bitcnt + 1'b1;
                    if (bitcnt == BIT_LAST) begin
                        if (byte_ok(int'(idx), nb)) begin
                            state <= C_ACKQ;
                            if (idx == IW'(1)) cmd_sel <= sel_of(nb);
                        end else begin
                            state <= C_IDLE;
                        end
                    end
                end
                C_ACKQ: if (ev.scl_fall) state <= C_ACK;
                C_ACK: if (ev.scl_fall) begin
                    if (idx == BYTE_LAST) begin
                        state <= C_WSTOP;
                    end else begin
                        state  <= C_RX;
                        idx    <= idx + 1'b1;
                        bitcnt <= '0;
                    end
                end
                C_WSTOP: if (ev.scl_fall) state <= C_IDLE;
                default: state <= C_IDLE;
            endcase
        end
    end

    assign sda_pull_o = (state == C_ACK);
    assign cmd_go     = (state == C_WSTOP) && ev.stop && vp_i && !prog_busy;

    // R4
    ack_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull_o) |-> $past(ev.scl_fall));

    // R12
    vp_drop_nack_chk: assert property (@(posedge clk) disable iff (rst)
        !vp_i |=> !sda_pull_o);

    // R11
    busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        prog_busy |=> !sda_pull_o);

endmodule

// File: rtl/trim_prog_timer.sv
module trim_prog_timer
    import trim_pkg::*;
#(
    parameter int PROG_CYCLES = 625000
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      go,
    input  trim_sel_t sel,
    input  logic      vp_i,
    output logic      prog1_o,
    output logic      prog2_o,
    output logic      busy_o,
    output logic      done_o
);

    localparam int CW = $clog2(PROG_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(PROG_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            busy_o  <= 1'b0;
            done_o  <= 1'b0;
            prog1_o <= 1'b0;
            prog2_o <= 1'b0;
        end else begin
            prog1_o <= 1'b0;
            prog2_o <= 1'b0;
            done_o  <= 1'b0;
            if (go && !busy_o) begin
                busy_o  <= 1'b1;
                cnt     <= LOAD;
                prog1_o <= (sel == SEL_T1);
                prog2_o <= (sel == SEL_T2);
            end else if (busy_o) begin
                if (cnt != '0) begin
                    cnt <= cnt - 1'b1;
                end else if (!vp_i) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end

    // R2
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({prog1_o, prog2_o}));

    // R2
    busy_with_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> (prog1_o || prog2_o));

    // R9
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o) && !$past(vp_i)));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

endmodule

// File: rtl/trim_seq.sv
module trim_seq
    import trim_pkg::*;
#(
    parameter int PROG_CYCLES = 625000
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    input  logic vp_i,
    output logic sda_pull_o,
    output logic prog1_o,
    output logic prog2_o,
    output logic busy_o,
    output logic done_o
);

    bus_ev_t   ev;
    logic      cmd_go;
    trim_sel_t cmd_sel;

    trim_bus_mon u_mon (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    trim_cmd_fsm u_cmd (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .vp_i       (vp_i),
        .prog_busy  (busy_o),
        .sda_pull_o (sda_pull_o),
        .cmd_go     (cmd_go),
        .cmd_sel    (cmd_sel)
    );

    trim_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .go      (cmd_go),
        .sel     (cmd_sel),
        .vp_i    (vp_i),
        .prog1_o (prog1_o),
        .prog2_o (prog2_o),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    // R11
    no_ack_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !sda_pull_o);

    // R2
    strobe_needs_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (prog1_o || prog2_o) |-> $past(ev.stop));

endmodule

// File: tb/sim_trim_seq.sv
`timescale 1ns/1ps
module sim_trim_seq;

    localparam int PROG = 300;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic vp = 1'b0;
    logic sda_bus;
    logic sda_pull_o, prog1_o, prog2_o, busy_o, done_o;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    int p1_n = 0, p2_n = 0, done_n = 0, busy_cyc = 0;

    always #4 clk = ~clk;

    assign sda_bus = m_sda & ~sda_pull_o;

    trim_seq #(.PROG_CYCLES(PROG)) u0 (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (m_scl),
        .sda_i      (sda_bus),
        .vp_i       (vp),
        .sda_pull_o (sda_pull_o),
        .prog1_o    (prog1_o),
        .prog2_o    (prog2_o),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    always @(negedge clk) begin
        if (prog1_o) p1_n++;
        if (prog2_o) p2_n++;
        if (done_o) done_n++;
        if (busy_o) busy_cyc++;
    end

    task automatic wc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; m_scl = 1'b1; wc(4);
        m_sda = 1'b0; wc(4);
        m_scl = 1'b0; wc(4);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wc(4);
        m_scl = 1'b1; wc(4);
        m_sda = 1'b1; wc(4);
    endtask

    task automatic bus_bit(input logic b);
        m_sda = b; wc(4);
        m_scl = 1'b1; wc(4);
        m_scl = 1'b0; wc(4);
    endtask

    task automatic bus_byte(input logic [7:0] d, output logic ack,
                            output logic pre, output logic mid, output logic post);
        pre = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            m_sda = d[i]; wc(4);
            m_scl = 1'b1; wc(4);
            if (i == 0) pre = sda_pull_o;
            m_scl = 1'b0; wc(4);
        end
        m_sda = 1'b1; wc(4);
        m_scl = 1'b1; wc(2);
        mid = sda_pull_o;
        ack = ~sda_bus;
        wc(2);
        m_scl = 1'b0; wc(4);
        post = sda_pull_o;
    endtask

    task automatic send3(input logic [7:0] b0, b1, b2, output logic a0, a1, a2);
        logic pr, md, po;
        bus_start();
        bus_byte(b0, a0, pr, md, po);
        bus_byte(b1, a1, pr, md, po);
        bus_byte(b2, a2, pr, md, po);
    endtask

    task automatic finish_op();
        wc(PROG + 20);
        vp = 1'b0;
        wc(10);
    endtask

    task automatic t_reset();
        wc(3);
        check(sda_pull_o == 0 && busy_o == 0, "R1 reset pull/busy", {sda_pull_o, busy_o}, 0);
        check(prog1_o == 0 && prog2_o == 0 && done_o == 0, "R1 reset strobes",
              {prog1_o, prog2_o, done_o}, 0);
        rst = 1'b0;
        wc(3);
        check(sda_pull_o == 0 && busy_o == 0 && done_o == 0, "R1 after reset",
              {sda_pull_o, busy_o, done_o}, 0);
    endtask

    task automatic t_trim1();
        logic a, pr, md, po;
        int s1 = p1_n, s2 = p2_n;
        vp = 1'b1; wc(4);
        bus_start();
        bus_byte(8'hA0, a, pr, md, po);
        check(pr == 0 && md == 1 && po == 0, "R4 ack window byte0", {pr, md, po}, 3'b010);
        check(a == 1, "R2 ack device byte", a, 1);
        bus_byte(8'h01, a, pr, md, po);
        check(pr == 0 && md == 1 && po == 0, "R4 ack window byte1", {pr, md, po}, 3'b010);
        bus_byte(8'h00, a, pr, md, po);
        check(a == 1 && po == 0, "R4 ack data byte", {a, po}, 2'b10);
        bus_stop();
        check(p1_n - s1 == 1, "R2 prog1 pulses", p1_n - s1, 1);
        check(p2_n - s2 == 0, "R2 no prog2", p2_n - s2, 0);
        check(busy_o == 1, "R2 busy raised", busy_o, 1);
        finish_op();
    endtask

    task automatic t_trim2();
        logic a0, a1, a2;
        int s1 = p1_n, s2 = p2_n;
        vp = 1'b1; wc(4);
        send3(8'hA0, 8'h09, 8'h00, a0, a1, a2);
        bus_stop();
        check(a0 && a1 && a2, "R3 acks", {a0, a1, a2}, 3'b111);
        check(p2_n - s2 == 1 && p1_n - s1 == 0, "R3 prog2 only",
              (p2_n - s2) * 10 + (p1_n - s1), 10);
        finish_op();
    endtask

    task automatic t_hold();
        logic a0, a1, a2;
        int sd = done_n;
        vp = 1'b1; wc(4);
        send3(8'hA0, 8'h01, 8'h00, a0, a1, a2);
        bus_stop();
        wc(2 * PROG);
        check(busy_o == 1 && done_n == sd, "R9 busy held while vp high",
              busy_o * 10 + (done_n - sd), 10);
        vp = 1'b0;
        wc(5);
        check(busy_o == 0, "R9 busy falls after release", busy_o, 0);
        check(done_n - sd == 1, "R9 single done pulse", done_n - sd, 1);
    endtask

    task automatic t_early_release();
        logic a0, a1, a2;
        int sd = done_n;
        int sb;
        vp = 1'b1; wc(4);
        send3(8'hA0, 8'h09, 8'h00, a0, a1, a2);
        sb = busy_cyc;
        bus_stop();
        vp = 1'b0;
        wc(PROG + 20);
        check(busy_cyc - sb >= PROG, "R10 minimum busy length", busy_cyc - sb, PROG);
        check(busy_o == 0 && done_n - sd == 1, "R10 done after period",
              busy_o * 10 + (done_n - sd), 1);
    endtask

    task automatic t_novp();
        logic a0, a1, a2;
        int s1 = p1_n, s2 = p2_n;
        vp = 1'b0; wc(4);
        send3(8'hA0, 8'h01, 8'h00, a0, a1, a2);
        bus_stop();
        wc(4);
        check(!a0 && !a1 && !a2, "R5 no ack without vp", {a0, a1, a2}, 0);
        check(p1_n == s1 && p2_n == s2 && busy_o == 0, "R5 no strobe without vp",
              (p1_n - s1) + (p2_n - s2) + busy_o, 0);
    endtask

    task automatic t_bad();
        logic a0, a1, a2, pr, md, po;
        int s1 = p1_n, s2 = p2_n;
        vp = 1'b1; wc(4);
        bus_start();
        bus_byte(8'hA2, a0, pr, md, po);
        bus_stop();
        check(a0 == 0, "R6 wrong device byte nack", a0, 0);
        bus_start();
        bus_byte(8'hA0, a0, pr, md, po);
        bus_byte(8'h02, a1, pr, md, po);
        bus_stop();
        check(a0 == 1 && a1 == 0, "R6 wrong word address nack", {a0, a1}, 2'b10);
        send3(8'hA0, 8'h01, 8'h5A, a0, a1, a2);
        bus_stop();
        wc(4);
        check(a1 == 1 && a2 == 0, "R6 nonzero data nack", {a1, a2}, 2'b10);
        check(p1_n == s1 && p2_n == s2 && busy_o == 0, "R6 no strobe on bad bytes",
              (p1_n - s1) + (p2_n - s2) + busy_o, 0);
    endtask

    task automatic t_early_stop();
        logic a0, a1, pr, md, po;
        int s1 = p1_n;
        vp = 1'b1; wc(4);
        bus_start();
        bus_byte(8'hA0, a0, pr, md, po);
        bus_byte(8'h01, a1, pr, md, po);
        bus_stop();
        wc(4);
        check(p1_n == s1 && busy_o == 0, "R7 early stop no strobe", (p1_n - s1) + busy_o, 0);
    endtask

    task automatic t_extra();
        logic a0, a1, a2;
        int s1 = p1_n, s2 = p2_n;
        vp = 1'b1; wc(4);
        send3(8'hA0, 8'h09, 8'h00, a0, a1, a2);
        bus_bit(1'b0);
        bus_stop();
        wc(4);
        check(p1_n == s1 && p2_n == s2 && busy_o == 0, "R8 extra clock aborts",
              (p1_n - s1) + (p2_n - s2) + busy_o, 0);
    endtask

    task automatic t_busy_ignore();
        logic a0, a1, a2;
        int s1, s2;
        vp = 1'b1; wc(4);
        send3(8'hA0, 8'h01, 8'h00, a0, a1, a2);
        bus_stop();
        s1 = p1_n; s2 = p2_n;
        send3(8'hA0, 8'h09, 8'h00, a0, a1, a2);
        bus_stop();
        check(busy_o == 1, "R11 still busy", busy_o, 1);
        check(!a0 && !a1 && !a2, "R11 no ack while busy", {a0, a1, a2}, 0);
        check(p1_n == s1 && p2_n == s2, "R11 no new strobe", (p1_n - s1) + (p2_n - s2), 0);
        finish_op();
    endtask

    task automatic t_vp_drop();
        logic a0, a1, pr, md, po;
        int s1 = p1_n;
        vp = 1'b1; wc(4);
        bus_start();
        bus_byte(8'hA0, a0, pr, md, po);
        vp = 1'b0;
        bus_byte(8'h01, a1, pr, md, po);
        vp = 1'b1;
        bus_byte(8'h00, a0, pr, md, po);
        bus_stop();
        wc(4);
        check(a1 == 0, "R12 nack after vp drop", a1, 0);
        check(p1_n == s1 && busy_o == 0, "R12 no strobe after vp drop", (p1_n - s1) + busy_o, 0);
    endtask

    initial begin
        t_reset();
        t_trim1();
        t_trim2();
        t_hold();
        t_early_release();
        t_novp();
        t_bad();
        t_early_stop();
        t_extra();
        t_busy_ignore();
        t_vp_drop();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1600000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule